// File: doc/BRIEF.md
# Interleaved Multi-Module Memory Scheduler

This block stands between one requester and a row of 2^k identical memory modules that share a single command bus. Each module needs several clocks to finish one access, but the bus can carry a new command every clock. The scheduler uses the lowest address bits as the module number. Consecutive word addresses therefore land in different modules, and their module cycles run side by side. Each accepted request is placed on the bus in the cycle after acceptance. The scheduler tracks how long each module stays busy and holds back any request aimed at a module that has not finished.

Requests enter on a valid/ready stream. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The requester must keep `req_valid` and the payload steady until that edge. `req_ready` depends on the target module, which comes from `req_addr`, and on `resp_ready`.

Read data leaves on a second valid/ready stream in the order the reads were accepted. A small queue of module numbers sets that order. When the requester holds `resp_ready` low, the data of the oldest read stays on `resp_data`. Its module counts as busy until the data is taken. Writes produce no response.

Top module: `ilv_mem_sched`

## Requirements
- R1: The module number of a request is `req_addr[BANK_BITS-1:0]`, and the word inside that module is `req_addr[ADDR_W-1:BANK_BITS]`. A write to address a ends up in module a mod 2^k, at word a / 2^k.
- R2: A request accepted at an edge drives exactly one bit of `bus_sel` (bit = module number) during the following cycle. In that same cycle, `bus_word`, `bus_we` (1 = write) and `bus_wdata` carry that request. In a cycle that follows no acceptance, `bus_sel` is all zero.
- R3: After a command to a module, no further command reaches that module for CYC_CLKS clock edges.
- R4: Requests to consecutive addresses are accepted on consecutive clock edges, for writes and for reads while `resp_ready` stays high.
- R5: A request to a module that is still in its cycle waits with `req_ready` low. Back-to-back writes to one module are accepted exactly CYC_CLKS edges apart.
- R6: Read responses come out in acceptance order, and each carries the word last written at its address.
- R7: With no other reads outstanding, a read accepted at an edge raises `resp_valid` CYC_CLKS-1 edges later.
- R8: A write never produces a response.
- R9: While `resp_valid` is high and `resp_ready` is low, both `resp_valid` and `resp_data` stay unchanged at the next edge.
- R10: After reset, `resp_valid` is low, `bus_sel` is zero, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken at this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address, module number in low bits |
| req_wdata | input | DATA_W | Write data |
| resp_valid | output | 1 | Read data offered |
| resp_ready | input | 1 | Requester takes read data |
| resp_data | output | DATA_W | Read data, oldest read first |
| bus_sel | output | NBANK | One-hot module select for this bus slot |
| bus_we | output | 1 | Bus slot is a write |
| bus_word | output | WORD_W | Word inside the selected module |
| bus_wdata | output | DATA_W | Write data for the selected module |
| mod_rdata | input | NBANK*DATA_W | Read data of each module, module i at bits i*DATA_W |

## Verification
A full ascending write sweep and a full ascending read sweep over every address check the address split and the one-request-per-edge rate. Without interleaving, these sweeps would stall. A stride equal to the module count sends every request to one module. This exposes the busy window and its exact length. A scattered read pattern, with `resp_ready` toggling, mixes stalls from a busy module with stalls from back-pressure. This separates ordering faults from data faults. A lone read measures the response latency.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_RD   = 2'd1,
    SLOT_WR   = 2'd2
  } slot_kind_e;
endpackage

// File: rtl/ilv_bank_slot.sv
module ilv_bank_slot #(
  parameter int DATA_W   = 16,
  parameter int CYC_CLKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              start_rd_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              free_o,
  output logic              hold_v_o,
  output logic [DATA_W-1:0] hold_d_o
);
  localparam int CNT_W = $clog2(CYC_CLKS);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYC_CLKS - 1);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;
  logic             hold_v_q;
  logic [DATA_W-1:0] hold_d_q;
  logic             capture;

  assign capture = (cnt_q == ONE) && pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= LOAD;
      pend_q <= start_rd_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - ONE;
      if (capture) pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v_q <= 1'b0;
      hold_d_q <= '0;
    end else if (capture) begin
      hold_v_q <= 1'b1;
      hold_d_q <= rdata_i;
    end else if (pop_i) begin
      hold_v_q <= 1'b0;
    end
  end

  assign free_o   = (cnt_q == '0) && (!hold_v_q || pop_i);
  assign hold_v_o = hold_v_q;
  assign hold_d_o = hold_d_q;
endmodule

// File: rtl/ilv_tag_fifo.sv
module ilv_tag_fifo #(
  parameter int W     = 2,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] push_d_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CW-1:0]    cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) begin
        mem_q[wp_q] <= push_d_i;
        wp_q        <= nxt(wp_q);
      end
      if (pop_i) rp_q <= nxt(rp_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + CW'(1);
      else if (pop_i && !push_i) cnt_q <= cnt_q - CW'(1);
    end
  end

  assign head_o  = mem_q[rp_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/ilv_bus_issue.sv
module ilv_bus_issue
  import ilv_pkg::*;
#(
  parameter int BANK_BITS = 2,
  parameter int WORD_W    = 4,
  parameter int DATA_W    = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fire_i,
  input  logic                   we_i,
  input  logic [BANK_BITS-1:0]   bank_i,
  input  logic [WORD_W-1:0]      word_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [(1<<BANK_BITS)-1:0] sel_o,
  output logic                   we_o,
  output logic [WORD_W-1:0]      word_o,
  output logic [DATA_W-1:0]      wdata_o
);
  localparam int NBANK = 1 << BANK_BITS;

  slot_kind_e        kind_q;
  logic [NBANK-1:0]  sel_q;
  logic [WORD_W-1:0] word_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q  <= SLOT_IDLE;
      sel_q   <= '0;
      word_q  <= '0;
      wdata_q <= '0;
    end else if (fire_i) begin
      kind_q  <= we_i ? SLOT_WR : SLOT_RD;
      sel_q   <= NBANK'(1) << bank_i;
      word_q  <= word_i;
      wdata_q <= wdata_i;
    end else begin
      kind_q <= SLOT_IDLE;
      sel_q  <= '0;
    end
  end

  assign sel_o   = sel_q;
  assign we_o    = (kind_q == SLOT_WR);
  assign word_o  = word_q;
  assign wdata_o = wdata_q;
endmodule

// File: rtl/ilv_mem_sched.sv
module ilv_mem_sched #(
  parameter int BANK_BITS = 2,
  parameter int WORD_W    = 4,
  parameter int DATA_W    = 16,
  parameter int CYC_CLKS  = 4,
  parameter int TAG_DEPTH = 4,
  localparam int NBANK    = 1 << BANK_BITS,
  localparam int ADDR_W   = BANK_BITS + WORD_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    resp_valid,
  input  logic                    resp_ready,
  output logic [DATA_W-1:0]       resp_data,
  output logic [NBANK-1:0]        bus_sel,
  output logic                    bus_we,
  output logic [WORD_W-1:0]       bus_word,
  output logic [DATA_W-1:0]       bus_wdata,
  input  logic [NBANK*DATA_W-1:0] mod_rdata
);
  logic [BANK_BITS-1:0] bank_idx;
  logic [WORD_W-1:0]    word_idx;
  logic [NBANK-1:0]     bank_free, hold_v, start_v, pop_v;
  logic [DATA_W-1:0]    hold_d [NBANK];
  logic [BANK_BITS-1:0] head;
  logic                 tag_empty, tag_full, resp_fire, accept;

  assign bank_idx = req_addr[BANK_BITS-1:0];
  assign word_idx = req_addr[ADDR_W-1:BANK_BITS];

  assign resp_valid = !tag_empty && hold_v[head];
  assign resp_data  = hold_d[head];
  assign resp_fire  = resp_valid && resp_ready;

  assign req_ready = bank_free[bank_idx] &&
                     (req_write || !tag_full || resp_fire);
  assign accept    = req_valid && req_ready;

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    assign start_v[i] = accept && (bank_idx == BANK_BITS'(i));
    assign pop_v[i]   = resp_fire && (head == BANK_BITS'(i));

    ilv_bank_slot #(
      .DATA_W  (DATA_W),
      .CYC_CLKS(CYC_CLKS)
    ) slot_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_v[i]),
      .start_rd_i(!req_write),
      .pop_i     (pop_v[i]),
      .rdata_i   (mod_rdata[i*DATA_W +: DATA_W]),
      .free_o    (bank_free[i]),
      .hold_v_o  (hold_v[i]),
      .hold_d_o  (hold_d[i])
    );
  end

  ilv_tag_fifo #(
    .W    (BANK_BITS),
    .DEPTH(TAG_DEPTH)
  ) tags_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (accept && !req_write),
    .push_d_i(bank_idx),
    .pop_i   (resp_fire),
    .head_o  (head),
    .empty_o (tag_empty),
    .full_o  (tag_full)
  );

  ilv_bus_issue #(
    .BANK_BITS(BANK_BITS),
    .WORD_W   (WORD_W),
    .DATA_W   (DATA_W)
  ) issue_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire_i (accept),
    .we_i   (req_write),
    .bank_i (bank_idx),
    .word_i (word_idx),
    .wdata_i(req_wdata),
    .sel_o  (bus_sel),
    .we_o   (bus_we),
    .word_o (bus_word),
    .wdata_o(bus_wdata)
  );
endmodule

// File: rtl/ilv_mem_sched_chk.sv
module ilv_mem_sched_chk #(
  parameter int BANK_BITS = 2,
  parameter int WORD_W    = 4,
  parameter int DATA_W    = 16,
  parameter int CYC_CLKS  = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          req_valid,
  input logic                          req_ready,
  input logic [BANK_BITS+WORD_W-1:0]   req_addr,
  input logic                          resp_valid,
  input logic                          resp_ready,
  input logic [DATA_W-1:0]             resp_data,
  input logic [(1<<BANK_BITS)-1:0]     bus_sel
);
  localparam int NBANK = 1 << BANK_BITS;
  localparam int GW    = $clog2(CYC_CLKS + 1);

  logic acc;
  assign acc = req_valid && req_ready;

  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_sel));

  // R2
  slot_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (bus_sel == (NBANK'(1) << $past(req_addr[BANK_BITS-1:0]))));

  // R2
  idle_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> (bus_sel == '0));

  // R9
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_data)));

  for (genvar i = 0; i < NBANK; i++) begin : g_gap
    logic [GW-1:0] gap_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                     gap_q <= GW'(CYC_CLKS);
      else if (bus_sel[i])            gap_q <= GW'(1);
      else if (gap_q < GW'(CYC_CLKS)) gap_q <= gap_q + GW'(1);
    end
    // R3
    module_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_sel[i] |-> (gap_q >= GW'(CYC_CLKS)));
  end
endmodule

bind ilv_mem_sched ilv_mem_sched_chk #(
  .BANK_BITS(BANK_BITS),
  .WORD_W   (WORD_W),
  .DATA_W   (DATA_W),
  .CYC_CLKS (CYC_CLKS)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .resp_valid(resp_valid),
  .resp_ready(resp_ready),
  .resp_data (resp_data),
  .bus_sel   (bus_sel)
);

// File: tb/ilv_mem_sched_tb_top.sv
`timescale 1ns/100ps
module ilv_mem_sched_tb_top;
  localparam int BB = 2, WW = 4, DW = 16, CYC = 4;
  localparam int NB = 1 << BB, AW = BB + WW, NW = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, resp_ready = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, resp_valid, bus_we;
  logic [DW-1:0] resp_data, bus_wdata;
  logic [NB-1:0] bus_sel;
  logic [WW-1:0] bus_word;
  logic [NB*DW-1:0] mod_rdata;

  always #2.5 clk = ~clk;

  ilv_mem_sched #(.BANK_BITS(BB), .WORD_W(WW), .DATA_W(DW), .CYC_CLKS(CYC),
                  .TAG_DEPTH(NB)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_data(resp_data),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_word(bus_word),
    .bus_wdata(bus_wdata), .mod_rdata(mod_rdata));

  int errors = 0, checks = 0, cyc = 0, resp_cnt = 0, gap_bad = 0;
  int rr_mode = 0;
  bit finished = 1'b0;
  logic [DW-1:0] ref_mem [NW];
  logic [DW-1:0] exp_q [$];
  int stamp [NW];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural modules
  logic [DW-1:0] mmem [NB][1<<WW];
  logic [DW-1:0] mrd  [NB];
  int last_cmd [NB];
  for (genvar g = 0; g < NB; g++) begin : g_mod
    assign mod_rdata[g*DW +: DW] = mrd[g];
    initial begin mrd[g] = '0; last_cmd[g] = -100; end
    always @(posedge clk) begin
      if (bus_sel[g]) begin
        if (cyc - last_cmd[g] < CYC) gap_bad++;
        last_cmd[g] <= cyc;
        if (bus_we) mmem[g][bus_word] <= bus_wdata;
        else        mrd[g] <= mmem[g][bus_word];
      end
    end
  end

  always @(posedge clk) cyc <= cyc + 1;

  // expected bus slot
  bit slot_v = 1'b0, slot_we = 1'b0;
  logic [AW-1:0] slot_a = '0;
  logic [DW-1:0] slot_d = '0;
  bit stall_p = 1'b0;
  logic [DW-1:0] stall_d = '0;

  always @(negedge clk) begin
    resp_ready = (rr_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
    #1;
    if (rst_n) begin
      if (slot_v) begin
        // R2
        check(bus_sel == (NB'(1) << slot_a[BB-1:0]) && bus_word == slot_a[AW-1:BB]
              && bus_we == slot_we && (!slot_we || bus_wdata == slot_d),
              "R2", {bus_sel, bus_word}, {NB'(1) << slot_a[BB-1:0], slot_a[AW-1:BB]});
        slot_v = 1'b0;
      end else if (bus_sel != '0) check(1'b0, "R2", bus_sel, 0);
      if (stall_p) begin
        // R9
        check(resp_valid && resp_data == stall_d, "R9", resp_data, stall_d);
      end
      stall_p = resp_valid && !resp_ready;
      stall_d = resp_data;
      if (resp_valid && resp_ready) begin
        resp_cnt++;
        if (exp_q.size() == 0) check(1'b0, "R8", resp_data, 0);
        else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          // R6
          check(resp_data == e, "R6", resp_data, e);
        end
      end
    end
  end

  task automatic send(input bit we, input int a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = we; req_addr = AW'(a); req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    stamp[a] = cyc;
    @(posedge clk);
    slot_v = 1'b1; slot_we = we; slot_a = AW'(a); slot_d = d;
    if (we) ref_mem[a] = d;
    else exp_q.push_back(ref_mem[a]);
    @(negedge clk);
    #0.5;
    req_valid = 1'b0;
  endtask

  // back-to-back variant: no idle cycle between requests
  task automatic stream(input bit we, input int a, input logic [DW-1:0] d);
    req_valid = 1'b1; req_write = we; req_addr = AW'(a); req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    stamp[a] = cyc;
    @(posedge clk);
    slot_v = 1'b1; slot_we = we; slot_a = AW'(a); slot_d = d;
    if (we) ref_mem[a] = d;
    else exp_q.push_back(ref_mem[a]);
    @(negedge clk);
    #0.5;
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int s);
    return DW'(a * 16'h0107 + s);
  endfunction

  task automatic drain();
    int n = 0;
    while ((exp_q.size() != 0 || resp_valid) && n < 1000) begin @(negedge clk); n++; end
    repeat (CYC + 2) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    check(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    int r0, c0, lat;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R10
    check(req_ready == 1'b1, "R10", req_ready, 1);
    check(resp_valid == 1'b0, "R10", resp_valid, 0);
    check(bus_sel == '0, "R10", bus_sel, 0);

    // R4 / R1: ascending write sweep, back-to-back
    @(negedge clk);
    for (int a = 0; a < NW; a++) stream(1'b1, a, pat(a, 3));
    req_valid = 1'b0;
    check(stamp[NW-1] - stamp[0] == NW - 1, "R4", stamp[NW-1] - stamp[0], NW - 1);
    r0 = resp_cnt;
    repeat (CYC + 2) @(negedge clk);
    // R8: writes produced no response
    check(resp_cnt == r0, "R8", resp_cnt, r0);
    // R1: module a mod NB holds word a / NB
    for (int a = 0; a < NW; a++)
      check(mmem[a % NB][a / NB] == pat(a, 3), "R1", mmem[a % NB][a / NB], pat(a, 3));

    // R7: lone read latency
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(5); #1;
    c0 = cyc;
    @(posedge clk);
    slot_v = 1'b1; slot_we = 1'b0; slot_a = AW'(5);
    exp_q.push_back(ref_mem[5]);
    @(negedge clk); #0.5; req_valid = 1'b0; #0.6;
    while (!resp_valid && cyc - c0 < 50) begin @(negedge clk); #1.1; end
    lat = cyc - c0;  // stamp precedes accepting edge by one count
    check(lat == CYC, "R7", lat, CYC);
    drain();

    // R4 / R6: ascending read sweep, back-to-back
    @(negedge clk);
    for (int a = 0; a < NW; a++) stream(1'b0, a, '0);
    req_valid = 1'b0;
    check(stamp[NW-1] - stamp[0] == NW - 1, "R4", stamp[NW-1] - stamp[0], NW - 1);
    drain();

    // R5: stride NB writes all hit module 0
    @(negedge clk);
    for (int j = 0; j < NW / NB; j++) stream(1'b1, j * NB, pat(j, 9));
    req_valid = 1'b0;
    for (int j = 1; j < NW / NB; j++)
      check(stamp[j*NB] - stamp[(j-1)*NB] == CYC, "R5",
            stamp[j*NB] - stamp[(j-1)*NB], CYC);
    repeat (CYC + 2) @(negedge clk);

    // R6 / R9: scattered reads and writes under back-pressure
    rr_mode = 1;
    @(negedge clk);
    for (int i = 0; i < 3 * NW; i++) begin
      int a = (i * 5 + i / 7) % NW;
      stream((i % 4) == 3, a, pat(i, 21));
    end
    req_valid = 1'b0;
    drain();
    rr_mode = 0;
    drain();
    check(exp_q.size() == 0, "R6", exp_q.size(), 0);
    // R3: behavioural modules never saw a command inside their cycle
    check(gap_bad == 0, "R3", gap_bad, 0);
    finish_run();
  end
endmodule